// File: doc/BRIEF.md
# Bus-Watching Write-Through Cache Controller

This block is a direct-mapped, write-through cache controller for one processor on a system bus shared with other bus masters. It holds one data word per line. A processor read that hits is answered in the same cycle, straight from the array. No bus cycle is issued for it. Every read that misses and every write go out as a single bus transaction. When a read miss completes, the returned word goes to the processor and is written into its line in the same cycle. A write that hits also updates the resident copy. A write that misses leaves the array as it is.

Coherency comes from watching the shared bus. When another master performs a write there, the controller compares the written address with the line it would occupy and drops that line if it is resident. Writes tagged with the controller's own master identifier are ignored. A region of high addresses can be marked as shared and non-cacheable. It is selected by a base value and a mask applied to the top address bits. Accesses inside it always go to the bus and are never filled. The array size, the address and data widths, the identifier width and the region decode are all parameters.

Top module: `snoop_wt_cache`

## Requirements
- R1: While `rst_ni` is low, and after it is released, every line is invalid, `bus_req_o` is low and `cpu_ready_o` is low. The first read of any address is therefore a miss.
- R2: A cacheable read miss raises `bus_req_o` with `bus_we_o`=0 and `bus_addr_o` equal to the processor address. In the cycle `bus_ack_i` is high, `cpu_ready_o` is high and `cpu_rdata_o` equals `bus_rdata_i`, and the line is filled.
- R3: A read to a resident line raises `cpu_ready_o` in the cycle of the request, returns the cached word, and issues no bus transaction.
- R4: Every processor write issues exactly one bus write with `bus_we_o`=1 and the processor's address and data, and completes in the `bus_ack_i` cycle. A write that hits also updates the cached word, so a following read hits and returns the new data.
- R5: A write that misses does not allocate. A line already resident at that index stays resident, and a later read of the written address misses.
- R6: A snoop with `snp_valid_i`=1, `snp_we_i`=1 and `snp_id_i` different from `SELF_ID`, at an address resident in the cache, invalidates that line, so the next read of it misses. A snoop write to the same index with a different tag leaves the resident line valid.
- R7: A snoop write whose `snp_id_i` equals `SELF_ID` has no effect on the array.
- R8: A snoop cycle with `snp_we_i`=0 has no effect on the array.
- R9: An address is non-cacheable when its top `NC_W` bits, masked by `NC_MASK`, equal `NC_BASE` masked by `NC_MASK`. Every read of such an address goes to the bus, including repeated reads, and is never filled.
- R10: If an invalidating snoop to the same address arrives in the same cycle as a processor read of a resident line, the snoop wins. The read is handled as a miss on the bus, and the line is not refilled by it.
- R11: If an invalidating snoop to the address of an outstanding read miss arrives while it waits for `bus_ack_i`, the returned word is delivered but not filled.
- R12: Once raised, `bus_req_o`, `bus_addr_o` and `bus_we_o` hold their values until the cycle `bus_ack_i` is high.
- R13: Two cacheable addresses with the same index bits (the low `log2(LINES)` address bits) and different tags evict each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_req_i | input | 1 | Processor request, held until `cpu_ready_o` |
| cpu_we_i | input | 1 | Processor write (1) or read (0) |
| cpu_addr_i | input | ADDR_W | Processor word address |
| cpu_wdata_i | input | DATA_W | Processor write data |
| cpu_ready_o | output | 1 | Request completes this cycle |
| cpu_rdata_o | output | DATA_W | Read data, valid with `cpu_ready_o` |
| bus_req_o | output | 1 | Bus transaction request (bus-side buffers enabled) |
| bus_we_o | output | 1 | Bus transaction is a write |
| bus_addr_o | output | ADDR_W | Bus word address |
| bus_wdata_o | output | DATA_W | Bus write data |
| bus_ack_i | input | 1 | Bus transaction completes this cycle |
| bus_rdata_i | input | DATA_W | Bus read data, valid with `bus_ack_i` |
| snp_valid_i | input | 1 | A transaction is visible on the shared bus |
| snp_we_i | input | 1 | The watched transaction is a write |
| snp_id_i | input | ID_W | Master identifier of the watched transaction |
| snp_addr_i | input | ADDR_W | Address of the watched transaction |

## Verification
The hardest cases to reach are the snoop races. In one, an invalidation meets a processor read of the same line in the same cycle. In the other, it meets a read miss that is still waiting for the bus. In both, the cycle of the snoop decides what gets cached. The bench drives the snoop from inside its processor-access task, either in the request cycle or in the first cycle after the bus request rises, with a responder whose latency is fixed. It then reads the address again and counts bus transactions to show the line was not filled. A reference model of valid bits and tags, together with a word-level memory updated by the other master's writes, gives the expected hit or miss and the expected data for sweeps over every address.

// File: rtl/snoop_wt_pkg.sv
package snoop_wt_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_BUS  = 1'b1
  } ctrl_state_e;
endpackage

// File: rtl/nc_region_decode.sv
module nc_region_decode #(
  parameter int unsigned        NC_W    = 4,
  parameter logic [NC_W-1:0]    NC_BASE = '1,
  parameter logic [NC_W-1:0]    NC_MASK = '1
) (
  input  logic [NC_W-1:0] top_i,
  output logic            nc_o
);
  assign nc_o = ((top_i ^ NC_BASE) & NC_MASK) == '0;
endmodule

// File: rtl/snoop_filter.sv
module snoop_filter #(
  parameter int unsigned     ID_W    = 2,
  parameter logic [ID_W-1:0] SELF_ID = '0
) (
  input  logic            valid_i,
  input  logic            we_i,
  input  logic [ID_W-1:0] id_i,
  output logic            inv_o
);
  // only foreign writes can make a copy stale
  assign inv_o = valid_i && we_i && (id_i != SELF_ID);
endmodule

// File: rtl/line_store.sv
module line_store #(
  parameter int unsigned LINES  = 64,
  parameter int unsigned TAG_W  = 10,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              upd_en_i,
  input  logic [DATA_W-1:0] upd_data_i,
  input  logic              fill_en_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic              inv_en_i,
  input  logic [IDX_W-1:0]  inv_idx_i,
  input  logic [TAG_W-1:0]  inv_tag_i
);
  logic              valid_a [LINES];
  logic [TAG_W-1:0]  tag_a   [LINES];
  logic [DATA_W-1:0] data_a  [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic              v_q;
    logic [TAG_W-1:0]  t_q;
    logic [DATA_W-1:0] d_q;
    logic              fill_here, upd_here, inv_here;

    assign fill_here = fill_en_i && (fill_idx_i == IDX_W'(i));
    assign upd_here  = upd_en_i  && (rd_idx_i   == IDX_W'(i));
    assign inv_here  = inv_en_i  && (inv_idx_i  == IDX_W'(i)) && v_q && (t_q == inv_tag_i);

    // fill beats invalidate: controller already drops fills that collide
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        v_q <= 1'b0;
      else if (fill_here) v_q <= 1'b1;
      else if (inv_here)  v_q <= 1'b0;
    end

    always_ff @(posedge clk_i) begin
      if (fill_here) begin
        t_q <= fill_tag_i;
        d_q <= fill_data_i;
      end else if (upd_here) begin
        d_q <= upd_data_i;
      end
    end

    assign valid_a[i] = v_q;
    assign tag_a[i]   = t_q;
    assign data_a[i]  = d_q;
  end

  assign rd_valid_o = valid_a[rd_idx_i];
  assign rd_tag_o   = tag_a[rd_idx_i];
  assign rd_data_o  = data_a[rd_idx_i];
endmodule

// File: rtl/wt_ctrl.sv
module wt_ctrl
  import snoop_wt_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 6,
  localparam int unsigned TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  input  logic              cpu_nc_i,
  output logic              cpu_ready_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  input  logic              lk_valid_i,
  input  logic [TAG_W-1:0]  lk_tag_i,
  input  logic [DATA_W-1:0] lk_data_i,
  input  logic              snp_inv_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              upd_en_o,
  output logic              fill_en_o,
  output logic [IDX_W-1:0]  fill_idx_o,
  output logic [TAG_W-1:0]  fill_tag_o
);
  ctrl_state_e       state_q;
  logic              req_q, we_q, alloc_q, kill_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  logic tag_eq, snp_on_cpu, snp_on_bus, hit, idle_req;

  assign tag_eq     = lk_valid_i && (lk_tag_i == cpu_addr_i[ADDR_W-1:IDX_W]);
  assign snp_on_cpu = snp_inv_i && (snp_addr_i == cpu_addr_i);
  assign snp_on_bus = snp_inv_i && (snp_addr_i == addr_q);
  // snoop on the same word in the same cycle turns a hit into a miss
  assign hit        = !cpu_nc_i && tag_eq && !snp_on_cpu;
  assign idle_req   = (state_q == ST_IDLE) && cpu_req_i;

  always_comb begin
    cpu_ready_o = 1'b0;
    cpu_rdata_o = bus_rdata_i;
    upd_en_o    = 1'b0;
    fill_en_o   = 1'b0;
    if (idle_req) begin
      if (!cpu_we_i && hit) begin
        cpu_ready_o = 1'b1;
        cpu_rdata_o = lk_data_i;
      end
      upd_en_o = cpu_we_i && hit;
    end else if (state_q == ST_BUS && bus_ack_i) begin
      cpu_ready_o = 1'b1;
      fill_en_o   = alloc_q && !kill_q && !snp_on_bus;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      alloc_q <= 1'b0;
      kill_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (cpu_req_i && (cpu_we_i || !hit)) begin
            state_q <= ST_BUS;
            req_q   <= 1'b1;
            we_q    <= cpu_we_i;
            addr_q  <= cpu_addr_i;
            wdata_q <= cpu_wdata_i;
            alloc_q <= !cpu_we_i && !cpu_nc_i;
            kill_q  <= snp_on_cpu;
          end
        end
        ST_BUS: begin
          if (bus_ack_i) begin
            state_q <= ST_IDLE;
            req_q   <= 1'b0;
          end else if (snp_on_bus) begin
            kill_q <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_req_o   = req_q;
  assign bus_we_o    = we_q;
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wdata_q;
  assign fill_idx_o  = addr_q[IDX_W-1:0];
  assign fill_tag_o  = addr_q[ADDR_W-1:IDX_W];
endmodule

// File: rtl/snoop_wt_cache.sv
module snoop_wt_cache #(
  parameter int unsigned     ADDR_W  = 16,
  parameter int unsigned     DATA_W  = 32,
  parameter int unsigned     LINES   = 64,
  parameter int unsigned     ID_W    = 2,
  parameter logic [ID_W-1:0] SELF_ID = '0,
  parameter int unsigned     NC_W    = 4,
  parameter logic [NC_W-1:0] NC_BASE = '1,
  parameter logic [NC_W-1:0] NC_MASK = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              snp_valid_i,
  input  logic              snp_we_i,
  input  logic [ID_W-1:0]   snp_id_i,
  input  logic [ADDR_W-1:0] snp_addr_i
);
  localparam int unsigned IDX_W = $clog2(LINES);
  localparam int unsigned TAG_W = ADDR_W - IDX_W;

  logic              nc, snp_inv, lk_valid, upd_en, fill_en;
  logic [TAG_W-1:0]  lk_tag, fill_tag;
  logic [DATA_W-1:0] lk_data;
  logic [IDX_W-1:0]  fill_idx;

  nc_region_decode #(
    .NC_W(NC_W), .NC_BASE(NC_BASE), .NC_MASK(NC_MASK)
  ) u_nc (
    .top_i (cpu_addr_i[ADDR_W-1 -: NC_W]),
    .nc_o  (nc)
  );

  snoop_filter #(.ID_W(ID_W), .SELF_ID(SELF_ID)) u_snp (
    .valid_i (snp_valid_i),
    .we_i    (snp_we_i),
    .id_i    (snp_id_i),
    .inv_o   (snp_inv)
  );

  line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_idx_i    (cpu_addr_i[IDX_W-1:0]),
    .rd_valid_o  (lk_valid),
    .rd_tag_o    (lk_tag),
    .rd_data_o   (lk_data),
    .upd_en_i    (upd_en),
    .upd_data_i  (cpu_wdata_i),
    .fill_en_i   (fill_en),
    .fill_idx_i  (fill_idx),
    .fill_tag_i  (fill_tag),
    .fill_data_i (bus_rdata_i),
    .inv_en_i    (snp_inv),
    .inv_idx_i   (snp_addr_i[IDX_W-1:0]),
    .inv_tag_i   (snp_addr_i[ADDR_W-1:IDX_W])
  );

  wt_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cpu_req_i   (cpu_req_i),
    .cpu_we_i    (cpu_we_i),
    .cpu_addr_i  (cpu_addr_i),
    .cpu_wdata_i (cpu_wdata_i),
    .cpu_nc_i    (nc),
    .cpu_ready_o (cpu_ready_o),
    .cpu_rdata_o (cpu_rdata_o),
    .lk_valid_i  (lk_valid),
    .lk_tag_i    (lk_tag),
    .lk_data_i   (lk_data),
    .snp_inv_i   (snp_inv),
    .snp_addr_i  (snp_addr_i),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_ack_i   (bus_ack_i),
    .bus_rdata_i (bus_rdata_i),
    .upd_en_o    (upd_en),
    .fill_en_o   (fill_en),
    .fill_idx_o  (fill_idx),
    .fill_tag_o  (fill_tag)
  );
endmodule

// File: rtl/snoop_wt_cache_chk.sv
module snoop_wt_cache_chk #(
  parameter int unsigned     ADDR_W  = 16,
  parameter int unsigned     NC_W    = 4,
  parameter logic [NC_W-1:0] NC_BASE = '1,
  parameter logic [NC_W-1:0] NC_MASK = '1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_req_i,
  input logic              cpu_we_i,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic              cpu_ready_o,
  input logic              bus_req_o,
  input logic              bus_we_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              bus_ack_i
);
  logic in_nc;
  assign in_nc = ((cpu_addr_i[ADDR_W-1 -: NC_W] ^ NC_BASE) & NC_MASK) == '0;

  a_r12_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o));

  a_r2_ack_completes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_ack_i |-> cpu_ready_o);

  a_r4_write_on_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && cpu_we_i && cpu_ready_o |-> bus_req_o && bus_we_o && bus_ack_i);

  a_r9_nc_on_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && in_nc && cpu_ready_o |-> bus_req_o && bus_ack_i && (bus_addr_o == cpu_addr_i));

  a_r3_ready_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o |-> cpu_req_i);

  a_r2_req_from_cpu: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_req_o) |-> $past(cpu_req_i));
endmodule

bind snoop_wt_cache snoop_wt_cache_chk #(
  .ADDR_W(ADDR_W), .NC_W(NC_W), .NC_BASE(NC_BASE), .NC_MASK(NC_MASK)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_req_i   (cpu_req_i),
  .cpu_we_i    (cpu_we_i),
  .cpu_addr_i  (cpu_addr_i),
  .cpu_ready_o (cpu_ready_o),
  .bus_req_o   (bus_req_o),
  .bus_we_o    (bus_we_o),
  .bus_addr_o  (bus_addr_o),
  .bus_ack_i   (bus_ack_i)
);

// File: tb/sim_snoop_wt_cache.sv
`timescale 1ns/1ps
module sim_snoop_wt_cache;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam logic [1:0] SELF = 2'd1;
  localparam logic [1:0] OTHER = 2'd2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_ready;
  logic [DW-1:0] cpu_rdata;
  logic bus_req, bus_we;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic bus_ack = 0;
  logic [DW-1:0] bus_rdata = '0;
  logic snp_valid = 0, snp_we = 0;
  logic [1:0] snp_id = '0;
  logic [AW-1:0] snp_addr = '0;

  always #5 clk = ~clk;

  snoop_wt_cache #(
    .ADDR_W(AW), .DATA_W(DW), .LINES(8), .ID_W(2), .SELF_ID(SELF),
    .NC_W(2), .NC_BASE(2'b11), .NC_MASK(2'b10)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_ready_o(cpu_ready), .cpu_rdata_o(cpu_rdata),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
    .bus_ack_i(bus_ack), .bus_rdata_i(bus_rdata),
    .snp_valid_i(snp_valid), .snp_we_i(snp_we), .snp_id_i(snp_id), .snp_addr_i(snp_addr)
  );

  int checks = 0, fails = 0, bus_cnt = 0;
  logic [DW-1:0] mem [256];
  logic       mv [8];
  logic [4:0] mt [8];
  logic [AW-1:0] last_addr;
  logic          last_we;
  logic [DW-1:0] last_wdata;

  function automatic bit is_nc(input logic [AW-1:0] a);
    return a[7] == 1'b1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus responder: ack two cycles after request; memory updated on write ack
  initial begin
    int wait_n;
    logic [AW-1:0] held;
    wait_n = 0;
    held = '0;
    forever begin
      @(negedge clk);
      if (bus_ack) begin
        bus_ack = 1'b0;
        wait_n = 0;
      end else if (bus_req) begin
        if (wait_n == 0) held = bus_addr;
        else check(bus_addr == held, "R12", int'(bus_addr), int'(held));
        wait_n++;
        if (wait_n == 3) begin
          bus_ack    = 1'b1;
          bus_rdata  = mem[bus_addr];
          last_addr  = bus_addr;
          last_we    = bus_we;
          last_wdata = bus_wdata;
          if (bus_we) mem[bus_addr] = bus_wdata;
          bus_cnt++;
        end
      end
    end
  end

  task automatic snoop_idle(input logic [1:0] id, input bit we, input logic [AW-1:0] a, input logic [DW-1:0] v);
    @(negedge clk);
    snp_valid = 1; snp_id = id; snp_we = we; snp_addr = a;
    if (we && id != SELF) begin
      mem[a] = v;
      if (mv[a[2:0]] && mt[a[2:0]] == a[7:3]) mv[a[2:0]] = 0;
    end
    @(negedge clk);
    snp_valid = 0;
  endtask

  // mode: 0 none, 1 foreign snoop write in request cycle, 2 in first bus-wait cycle
  task automatic access(input string req, input bit we, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd, input int mode);
    int n0, lat;
    bit done, exp_hit, killed;
    logic [2:0] ix;
    logic [DW-1:0] rd;
    ix = a[2:0];
    killed = (mode != 0);
    exp_hit = !we && !is_nc(a) && mv[ix] && mt[ix] == a[7:3] && mode != 1;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    n0 = bus_cnt; lat = 0; done = 0; rd = '0;
    if (mode == 1) begin
      snp_valid = 1; snp_we = 1; snp_id = OTHER; snp_addr = a;
      mem[a] = mem[a] ^ 16'h0F0F;
      if (mv[ix] && mt[ix] == a[7:3]) mv[ix] = 0;
    end
    while (!done) begin
      #1;
      if (cpu_ready) begin rd = cpu_rdata; done = 1; end
      @(negedge clk);
      if (!done) begin
        lat++;
        if (lat == 1 && mode == 1) snp_valid = 0;
        if (lat == 1 && mode == 2) begin
          snp_valid = 1; snp_we = 1; snp_id = OTHER; snp_addr = a;
          mem[a] = mem[a] ^ 16'h3C3C;
          if (mv[ix] && mt[ix] == a[7:3]) mv[ix] = 0;
        end
        if (lat == 2 && mode == 2) snp_valid = 0;
        if (lat > 40) begin check(0, {req, " timeout"}, lat, 0); done = 1; end
      end
    end
    cpu_req = 0; snp_valid = 0;
    check((bus_cnt - n0) == (exp_hit ? 0 : 1), {req, " bus count"}, bus_cnt - n0, exp_hit ? 0 : 1);
    if (exp_hit) check(lat == 0, {req, " hit latency"}, lat, 0);
    if (!exp_hit) begin
      check(last_addr == a && last_we == we, {req, " bus addr/we"}, int'(last_addr), int'(a));
      if (we) check(last_wdata == wd, {req, " bus wdata"}, int'(last_wdata), int'(wd));
    end
    if (!we) check(rd == mem[a], {req, " rdata"}, int'(rd), int'(mem[a]));
    if (!we && !is_nc(a) && !exp_hit && !killed) begin
      mv[ix] = 1; mt[ix] = a[7:3];
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 97 + 16'h1234);
    for (int i = 0; i < 8; i++) begin mv[i] = 0; mt[i] = '0; end
    repeat (3) @(negedge clk);
    check(cpu_ready == 0 && bus_req == 0, "R1 in reset", {cpu_ready, bus_req}, 0);
    rst_n = 1;
    @(negedge clk);
    check(cpu_ready == 0 && bus_req == 0, "R1 after reset", {cpu_ready, bus_req}, 0);

    // R2, R3, R9: every address read twice
    for (int a = 0; a < 256; a++) begin
      access(is_nc(8'(a)) ? "R9" : "R2", 0, 8'(a), '0, 0);
      access(is_nc(8'(a)) ? "R9" : "R3", 0, 8'(a), '0, 0);
    end
    // R13: index conflicts
    for (int i = 0; i < 8; i++) begin
      access("R13", 0, 8'(i), '0, 0);
      access("R13", 0, 8'(i + 8), '0, 0);
      access("R13", 0, 8'(i), '0, 0);
    end
    // R4: write hit updates copy and goes to bus
    for (int a = 0; a < 128; a++) begin
      access("R4", 0, 8'(a), '0, 0);
      access("R4", 1, 8'(a), 16'(a ^ 16'h5A5A), 0);
      access("R4", 0, 8'(a), '0, 0);
    end
    // R5: write miss does not allocate
    for (int i = 0; i < 8; i++) begin
      access("R5", 0, 8'(i), '0, 0);
      access("R5", 1, 8'(i + 16), 16'hBEEF, 0);
      access("R5", 0, 8'(i), '0, 0);
      access("R5", 0, 8'(i + 16), '0, 0);
    end
    // R6, R7, R8: snoops while idle
    for (int i = 0; i < 16; i++) begin
      logic [AW-1:0] a;
      a = 8'(i * 3);
      access("R6", 0, a, '0, 0);
      snoop_idle(OTHER, 1, a ^ 8'h08, 16'(i + 16'h7000));
      access("R6 other tag", 0, a, '0, 0);
      snoop_idle(OTHER, 1, a, 16'(i + 16'h6000));
      access("R6", 0, a, '0, 0);
      snoop_idle(SELF, 1, a, '0);
      access("R7", 0, a, '0, 0);
      snoop_idle(OTHER, 0, a, '0);
      access("R8", 0, a, '0, 0);
    end
    // R10: same-cycle snoop on a resident line
    for (int i = 0; i < 8; i++) begin
      access("R10", 0, 8'(i + 40), '0, 0);
      access("R10", 0, 8'(i + 40), '0, 1);
      access("R10", 0, 8'(i + 40), '0, 0);
      access("R10", 0, 8'(i + 40), '0, 0);
    end
    // R11: snoop during outstanding miss
    for (int i = 0; i < 8; i++) begin
      access("R11", 0, 8'(i + 64), '0, 2);
      access("R11", 0, 8'(i + 64), '0, 0);
      access("R11", 0, 8'(i + 64), '0, 0);
    end
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule